// File: doc/BRIEF.md
# Lane-wise Floating-Point Min/Max Selector

This block takes two 128-bit vectors of IEEE-754 values and, lane by lane, returns either the smaller or the larger of each pair of operands. An element-size code chooses the lane layout: four single-precision lanes or two double-precision lanes. No arithmetic is involved. Each lane decides from the sign bit, then from the exponent and mantissa taken together as an unsigned magnitude, and from the NaN rules.

Two NaN policies are available, chosen by a mode field. The lenient mode follows the usual library min/max convention, where a lone NaN operand is passed over. Every other mode is strict: any NaN operand makes the lane result a NaN. A single-lane flag limits the work to lane 0 and writes the other lanes as zero. The result sits in one output register behind a valid/ready handshake, so the block can be placed directly in a streaming datapath.

Top module: `lane_minmax_sel`

## Requirements
- R1: Element-size code 2 gives four 32-bit lanes, with lane k at result bits [32k+31:32k]. Code 3 gives two 64-bit lanes, with lane k at bits [64k+63:64k]. Each lane is computed from the same bit slice of `a_vec` and `b_vec`.
- R2: Any other element-size code produces an all-zero result with `out_bad_size` = 1. A legal code gives `out_bad_size` = 0.
- R3: When the two operands of a lane differ in sign, max (`sel_max` = 1) returns the operand whose sign bit is clear and min (`sel_max` = 0) returns the operand whose sign bit is set. This includes +0 against -0.
- R4: When both operands share a sign, the lane orders them by magnitude (the bits below the sign). For two negative values, the larger magnitude is the smaller value.
- R5: In mode 3, if exactly one operand of a lane is a NaN (exponent all ones, mantissa non-zero), the lane returns the other operand unchanged. An infinity is not a NaN.
- R6: In mode 3, if both operands are NaN, the lane returns the default quiet NaN: 32'h7FC00000 for 32-bit lanes and 64'h7FF8000000000000 for 64-bit lanes.
- R7: In any mode other than 3, a NaN in either operand makes the lane return the default quiet NaN of R6.
- R8: With `single_lane` = 1, only lane 0 is computed and every other lane of the result is zero.
- R9: `in_ready` is high whenever the output register is empty or is being drained (`out_ready` = 1). A result is valid on `out_valid` in the cycle after its inputs are accepted. `result` and `out_bad_size` stay unchanged while `out_valid` is high and `out_ready` is low. After reset, `out_valid` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are present |
| in_ready | output | 1 | Block can accept an operation this cycle |
| a_vec | input | 128 | First operand vector |
| b_vec | input | 128 | Second operand vector |
| sel_max | input | 1 | 1 selects maximum, 0 selects minimum |
| mode | input | 4 | NaN policy; 3 is lenient, all others strict |
| elem_size | input | 4 | 2 for 32-bit lanes, 3 for 64-bit lanes |
| single_lane | input | 1 | Compute lane 0 only, zero the others |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 128 | Selected values, lane 0 in the low bits |
| out_bad_size | output | 1 | Element-size code was illegal |

## Verification
Each result is due on the first rising edge after its acceptance edge. When the consumer stalls, the same result is due again on every later edge until it is taken. The bench drives operands at falling edges and records the expected vector in a queue only once `in_ready` is seen high for that operation. A monitor pops and compares the queue at each falling edge where `out_valid` and `out_ready` are both high, which is exactly the cycle of transfer. During stalls, it also checks at every falling edge that the held result has not moved. The consumer's `out_ready` is randomly withdrawn in later phases, so both the back-to-back and the stalled timing are exercised.

// File: rtl/minmax_pkg.sv
package minmax_pkg;
  localparam logic [3:0] SZ_WORD  = 4'd2;
  localparam logic [3:0] SZ_DWORD = 4'd3;
  localparam logic [3:0] MODE_LENIENT = 4'd3;

  function automatic logic size_is_legal(input logic [3:0] sz);
    return (sz == SZ_WORD) || (sz == SZ_DWORD);
  endfunction
endpackage

// File: rtl/fp_lane_sel.sv
module fp_lane_sel #(
  parameter int W  = 32,
  parameter int EW = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_max,
  input  logic         lenient,
  output logic [W-1:0] y
);
  localparam int MW = W - 1 - EW;
  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  logic a_nan, b_nan, a_neg, b_neg, mag_gt, a_greater, a_wins;

  always_comb begin
    a_nan = (&a[W-2 -: EW]) && (|a[MW-1:0]);
    b_nan = (&b[W-2 -: EW]) && (|b[MW-1:0]);
    a_neg = a[W-1];
    b_neg = b[W-1];
    mag_gt = a[W-2:0] > b[W-2:0];
    if (a_neg != b_neg) begin
      a_greater = !a_neg;
    end else if (a_neg) begin
      a_greater = (a[W-2:0] < b[W-2:0]);
    end else begin
      a_greater = mag_gt;
    end
    a_wins = sel_max ? a_greater : !a_greater;

    if (a_nan && b_nan) begin
      y = QNAN;
    end else if (a_nan || b_nan) begin
      if (lenient) y = a_nan ? b : a;
      else         y = QNAN;
    end else begin
      y = a_wins ? a : b;
    end
  end
endmodule

// File: rtl/minmax_out_reg.sv
module minmax_out_reg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d_res,
  input  logic         d_bad,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q_res,
  output logic         q_bad
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q_res     <= '0;
      q_bad     <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        q_res     <= d_res;
        q_bad     <= d_bad;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lane_minmax_sel.sv
module lane_minmax_sel
  import minmax_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int SP_W  = 32,
  parameter int SP_EW = 8,
  parameter int DP_W  = 64,
  parameter int DP_EW = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] a_vec,
  input  logic [VEC_W-1:0] b_vec,
  input  logic             sel_max,
  input  logic [3:0]       mode,
  input  logic [3:0]       elem_size,
  input  logic             single_lane,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] result,
  output logic             out_bad_size
);
  localparam int N_SP = VEC_W / SP_W;
  localparam int N_DP = VEC_W / DP_W;

  logic             lenient;
  logic [VEC_W-1:0] sp_vec, dp_vec, next_res;
  logic             next_bad;

  assign lenient = (mode == MODE_LENIENT);

  for (genvar g = 0; g < N_SP; g++) begin : g_sp
    logic [SP_W-1:0] y;
    fp_lane_sel #(.W(SP_W), .EW(SP_EW)) u_lane (
      .a(a_vec[g*SP_W +: SP_W]), .b(b_vec[g*SP_W +: SP_W]),
      .sel_max(sel_max), .lenient(lenient), .y(y));
    if (g == 0) begin : g_first
      assign sp_vec[g*SP_W +: SP_W] = y;
    end else begin : g_rest
      assign sp_vec[g*SP_W +: SP_W] = single_lane ? '0 : y;
    end
  end

  for (genvar g = 0; g < N_DP; g++) begin : g_dp
    logic [DP_W-1:0] y;
    fp_lane_sel #(.W(DP_W), .EW(DP_EW)) u_lane (
      .a(a_vec[g*DP_W +: DP_W]), .b(b_vec[g*DP_W +: DP_W]),
      .sel_max(sel_max), .lenient(lenient), .y(y));
    if (g == 0) begin : g_first
      assign dp_vec[g*DP_W +: DP_W] = y;
    end else begin : g_rest
      assign dp_vec[g*DP_W +: DP_W] = single_lane ? '0 : y;
    end
  end

  always_comb begin
    next_bad = !size_is_legal(elem_size);
    case (elem_size)
      SZ_WORD:  next_res = sp_vec;
      SZ_DWORD: next_res = dp_vec;
      default:  next_res = '0;
    endcase
  end

  minmax_out_reg #(.W(VEC_W)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .d_res(next_res), .d_bad(next_bad),
    .out_valid(out_valid), .out_ready(out_ready),
    .q_res(result), .q_bad(out_bad_size));
endmodule

// File: rtl/minmax_checker.sv
module minmax_checker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [30:0]      a_lo,
  input logic [3:0]       mode,
  input logic [3:0]       elem_size,
  input logic             single_lane,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] result,
  input logic             out_bad_size
);
  a_r9_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(out_bad_size));

  a_r2_bad_size_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_bad_size |-> result == '0);

  a_r2_legal_no_flag: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (elem_size == 4'd2 || elem_size == 4'd3) |=> !out_bad_size);

  a_r8_single_upper_zero: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && single_lane |=> result[VEC_W-1:64] == '0);

  a_r7_strict_nan: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && mode != 4'd3 && elem_size == 4'd2
      && (&a_lo[30:23]) && (|a_lo[22:0]) |=> result[31:0] == 32'h7FC00000);
endmodule

bind lane_minmax_sel minmax_checker #(.VEC_W(VEC_W)) u_minmax_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .a_lo(a_vec[30:0]), .mode(mode), .elem_size(elem_size),
  .single_lane(single_lane), .out_valid(out_valid), .out_ready(out_ready),
  .result(result), .out_bad_size(out_bad_size));

// File: tb/test_lane_minmax_sel.sv
`timescale 1ns/1ps
module test_lane_minmax_sel;
  logic         clk = 0;
  logic         rst = 1;
  logic         in_valid = 0;
  logic         in_ready;
  logic [127:0] a_vec = '0, b_vec = '0;
  logic         sel_max = 0;
  logic [3:0]   mode = 0, elem_size = 2;
  logic         single_lane = 0;
  logic         out_valid;
  logic         out_ready = 1;
  logic [127:0] result;
  logic         out_bad_size;

  int checks = 0, errors = 0;
  bit stall_en = 0, done = 0;
  logic [127:0] q_res[$];
  logic         q_bad[$];
  string        q_tag[$];

  always #2.5 clk = ~clk;

  lane_minmax_sel i_lane_minmax_sel (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .a_vec(a_vec), .b_vec(b_vec), .sel_max(sel_max), .mode(mode),
    .elem_size(elem_size), .single_lane(single_lane),
    .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .out_bad_size(out_bad_size));

  // Reference: map each value to an unsigned key whose order is the value order.
  function automatic logic [63:0] ref_lane(logic [63:0] a, logic [63:0] b,
                                           bit dbl, bit mx, logic [3:0] md);
    logic an, bn;
    logic [63:0] qn, ka, kb;
    if (dbl) begin
      an = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
      bn = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
      qn = 64'h7FF8000000000000;
      ka = a[63] ? ~a : a ^ 64'h8000000000000000;
      kb = b[63] ? ~b : b ^ 64'h8000000000000000;
    end else begin
      an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
      bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
      qn = 64'h7FC00000;
      ka = {32'h0, a[31] ? ~a[31:0] : a[31:0] ^ 32'h80000000};
      kb = {32'h0, b[31] ? ~b[31:0] : b[31:0] ^ 32'h80000000};
    end
    if (an && bn) return qn;
    if (an || bn) return (md == 4'd3) ? (an ? b : a) : qn;
    if (mx) return (ka >= kb) ? a : b;
    return (ka <= kb) ? a : b;
  endfunction

  task automatic send(string tag, logic [127:0] a, logic [127:0] b, bit mx,
                      logic [3:0] md, logic [3:0] sz, bit single);
    logic [127:0] exp_r = '0;
    logic [63:0]  t;
    bit           bad = 0;
    if (sz == 4'd2) begin
      for (int k = 0; k < 4; k++) begin
        t = ref_lane({32'h0, a[k*32 +: 32]}, {32'h0, b[k*32 +: 32]}, 0, mx, md);
        exp_r[k*32 +: 32] = (single && k > 0) ? 32'h0 : t[31:0];
      end
    end else if (sz == 4'd3) begin
      for (int k = 0; k < 2; k++) begin
        t = ref_lane(a[k*64 +: 64], b[k*64 +: 64], 1, mx, md);
        exp_r[k*64 +: 64] = (single && k > 0) ? 64'h0 : t;
      end
    end else bad = 1;
    a_vec = a; b_vec = b; sel_max = mx; mode = md; elem_size = sz;
    single_lane = single; in_valid = 1;
    while (!in_ready) @(negedge clk);
    q_res.push_back(exp_r); q_bad.push_back(bad); q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 0;
  endtask

  always @(posedge clk) out_ready <= stall_en ? ($urandom % 3 != 0) : 1'b1;

  // Monitor: hold check during stalls, scoreboard compare at transfer.
  logic         prev_stall = 0;
  logic [127:0] prev_res;
  logic         prev_bad;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        checks++;
        if (!out_valid || result !== prev_res || out_bad_size !== prev_bad) begin
          errors++;
          $display("FAIL R9 hold: valid=%b res=%h bad=%b exp res=%h bad=%b",
                   out_valid, result, out_bad_size, prev_res, prev_bad);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (q_res.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected output: res=%h exp none", result);
        end else begin
          logic [127:0] er;
          logic eb;
          string tg;
          er = q_res.pop_front(); eb = q_bad.pop_front(); tg = q_tag.pop_front();
          if (result !== er || out_bad_size !== eb) begin
            errors++;
            $display("FAIL %s: res=%h bad=%b exp res=%h bad=%b",
                     tg, result, out_bad_size, er, eb);
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_res   = result;
      prev_bad   = out_bad_size;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R9 reset: valid=%b ready=%b exp 0 1", out_valid, in_ready);
    end
    // R1 layouts
    send("R1 word max", {32'h40000000, 32'h3F800000, 32'hC0000000, 32'h3F800000},
         {32'h3F800000, 32'h40000000, 32'hBF800000, 32'h00000000}, 1, 0, 2, 0);
    send("R1 dword min", {64'h3FF0000000000000, 64'h4000000000000000},
         {64'h4000000000000000, 64'hBFF0000000000000}, 0, 1, 3, 0);
    // R3 signed zero
    send("R3 zero max", {32'h80000000, 32'h0, 32'h80000000, 32'h3F800000},
         {32'h0, 32'h80000000, 32'hBF800000, 32'hBF800000}, 1, 0, 2, 0);
    send("R3 zero min", {64'h8000000000000000, 64'h0},
         {64'h0, 64'h8000000000000000}, 0, 3, 3, 0);
    // R4 same sign magnitudes
    send("R4 neg max", {64'hC008000000000000, 64'hBFF0000000000000},
         {64'hBFF0000000000000, 64'hC008000000000000}, 1, 0, 3, 0);
    send("R4 neg min", {32'hC0000000, 32'hBF800000, 32'h40000000, 32'h3F800000},
         {32'hBF800000, 32'hC0000000, 32'h3F800000, 32'h40000000}, 0, 0, 2, 0);
    // R5 / R6 lenient mode
    send("R5 one nan", {32'h7FC00001, 32'h3F800000, 32'h7F800000, 32'hBF800000},
         {32'h40000000, 32'hFF800001, 32'h3F800000, 32'h7F800001}, 1, 3, 2, 0);
    send("R6 both nan", {64'h7FF0000000000001, 64'hFFF8000000000005},
         {64'hFFF0000000000002, 64'h7FF4000000000000}, 0, 3, 3, 0);
    // R7 strict modes
    send("R7 strict word", {32'h7FC00001, 32'h3F800000, 32'h7F800000, 32'hBF800000},
         {32'h40000000, 32'hFF800001, 32'h3F800000, 32'h7F800001}, 1, 0, 2, 0);
    send("R7 strict dword", {64'h7FF0000000000000, 64'h3FF0000000000000},
         {64'h4000000000000000, 64'h7FF0000000000009}, 0, 1, 3, 0);
    // R8 single lane
    send("R8 single word", {32'h40000000, 32'h3F800000, 32'hC0000000, 32'h3F800000},
         {32'h3F800000, 32'h40000000, 32'hBF800000, 32'h40000000}, 1, 0, 2, 1);
    send("R8 single dword", {64'h3FF0000000000000, 64'hBFF0000000000000},
         {64'h4000000000000000, 64'h3FF0000000000000}, 0, 3, 3, 1);
    // R2 illegal codes
    send("R2 size 0", {4{32'h3F800000}}, {4{32'h40000000}}, 1, 0, 0, 0);
    send("R2 size 4", {4{32'h3F800000}}, {4{32'h40000000}}, 0, 3, 4, 0);
    // R9 with backpressure, mixed operands (R1 R4 R5 R7 exercised again)
    stall_en = 1;
    for (int i = 0; i < 60; i++) begin
      logic [127:0] ra, rb;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = (i % 4 == 0) ? ra ^ 128'h80000000_00000000_80000000_00000000
                        : {$urandom, $urandom, $urandom, $urandom};
      if (i % 5 == 1) ra[30:0] = 31'h7F800003;
      send("R9 stream", ra, rb, i[0], (i % 3 == 0) ? 4'd3 : 4'd0,
           (i % 7 == 6) ? 4'd5 : ((i % 2 == 0) ? 4'd2 : 4'd3), (i % 9 == 8));
    end
    stall_en = 0;
    while (q_res.size() != 0 || out_valid) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule